// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the slave side of the page-write path of a serial NOR flash. A host drives a serial clock, an active-low select and one data-in line. Command, address and data bits are sampled on rising serial-clock edges, most significant bit first. The block recognises three commands: set the write latch, read the status byte, and program a page.

A page program stages up to one 256-byte page in a local buffer and records which offsets were received. When select is released on a whole-byte boundary, the block commits those bytes to a small on-chip array. The commit is a self-timed cycle whose progress shows in the status byte. Programming can only clear bits. A set of three protection bits keeps the upper pages of the array from being written.

The serial pins are oversampled by the system clock, so the serial clock must run well below it. Bits are held for at least three system clocks per phase. A side read port lets the surrounding logic observe the array contents.

Top module: `spp_flash_pp`

## Requirements
- R1: After reset the status byte reads 00h when the protection input is 0, and `miso` is 0.
- R2: Opcode 06h sets the write latch (status bit 1). The opcode is ignored while a program cycle is running.
- R3: Opcode 05h returns the status byte on `miso`, MSB first, changing after falling serial-clock edges. The byte repeats for as long as select stays low. Bits [4:2] are the protection input, bit 1 is the write latch, bit 0 is the in-progress flag and bits [7:5] read 0. `miso` is 0 while select is high.
- R4: A program opcode (02h) that arrives while the write latch is 0 changes no array byte.
- R5: A program is opcode 02h, then three address bytes, then data bytes. The page index is taken from address bits [8 +: PAGE_W] and the starting offset from bits [7:0]. Bits 23 and 22 have no effect on the target.
- R6: Each programmed byte becomes the old byte ANDed with the received byte. Offsets that received no byte keep their contents.
- R7: The offset advances by one per data byte and wraps from FFh to 00h inside the same page.
- R8: When more than 256 data bytes are sent, each offset holds the last byte sent to it.
- R9: If select rises at a position that is not a whole byte, or before any data byte, no byte is programmed and the write latch keeps its value.
- R10: A valid program holds status bit 0 at 1 for 256+PROG_WAIT cycles and then returns it to 0. The write latch reads 0 from the start of that cycle.
- R11: With protection value p, the top (PAGES·2^p)/128 pages are protected, and a program aimed at one of them changes nothing. Other pages still program.
- R12: A program opcode received while a cycle is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out (status) |
| bp | input | 3 | Protection level |
| peek_addr | input | PAGE_W+8 | Array observation address |
| peek_data | output | 8 | Array byte at `peek_addr` |

## Verification
Each serial edge is seen two system clocks after the pin moves, through one sampling stage and one edge stage. A status bit is therefore valid on `miso` three clocks after a falling serial clock, and the bench samples it on the fourth negative clock edge. A commit starts within three clocks of select rising. The bench reads status immediately to catch the busy flag. It then waits PROG_WAIT+300 clocks, longer than the 256+PROG_WAIT busy window, before it reads array bytes through the side port on a negative edge. Expected bytes come from the AND rule, the offset wrap and the last-byte-wins rule. The scoreboard matches each expected item to its observation in order.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam int PG_BYTES = 256;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_PROG = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_DATA, ST_STAT, ST_SKIP
  } seq_e;

  typedef logic [PG_BYTES-1:0][7:0] pbuf_t;
endpackage

// File: rtl/spp_shift.sv
module spp_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       rd_active,
  input  logic [7:0] stat,
  output logic       s_cs,
  output logic       cs_rise,
  output logic       byte_stb,
  output logic [7:0] rx_byte,
  output logic       aligned,
  output logic       miso
);
  logic       sclk_q, sclk_d, cs_q, cs_d, mosi_q;
  logic [2:0] bitcnt, bit_n, obit, obit_n;
  logic [6:0] shreg, sh_n;
  logic       miso_q, miso_n;
  logic       rise, fall;

  always_comb begin
    rise   = sclk_q & ~sclk_d & ~cs_q;
    fall   = ~sclk_q & sclk_d & ~cs_q;
    bit_n  = bitcnt;
    sh_n   = shreg;
    obit_n = obit;
    miso_n = miso_q;
    if (cs_q) begin
      bit_n  = '0;
      obit_n = '0;
      miso_n = 1'b0;
    end else begin
      if (rise) begin
        sh_n  = {shreg[5:0], mosi_q};
        bit_n = bitcnt + 3'd1;
      end
      if (fall && rd_active) begin
        miso_n = stat[~obit];
        obit_n = obit + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; sclk_d <= 1'b0;
      cs_q   <= 1'b1; cs_d   <= 1'b1;
      mosi_q <= 1'b0;
      bitcnt <= '0;   shreg  <= '0;
      obit   <= '0;   miso_q <= 1'b0;
    end else begin
      sclk_q <= sclk;  sclk_d <= sclk_q;
      cs_q   <= cs_n;  cs_d   <= cs_q;
      mosi_q <= mosi;
      bitcnt <= bit_n; shreg  <= sh_n;
      obit   <= obit_n; miso_q <= miso_n;
    end
  end

  assign s_cs     = cs_q;
  assign cs_rise  = cs_q & ~cs_d;
  assign byte_stb = rise && (bitcnt == 3'd7);
  assign rx_byte  = {shreg, mosi_q};
  assign aligned  = (bitcnt == 3'd0);
  assign miso     = miso_q;

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> !miso_q); // R3
endmodule

// File: rtl/spp_ctrl.sv
module spp_ctrl #(
  parameter int PAGES  = 4,
  parameter int PAGE_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_cs,
  input  logic                 cs_rise,
  input  logic                 byte_stb,
  input  logic [7:0]           rx_byte,
  input  logic                 aligned,
  input  logic                 busy,
  input  logic [2:0]           bp,
  output logic                 rd_active,
  output logic [7:0]           stat,
  output logic                 go,
  output logic [PAGE_W-1:0]    go_page,
  output spp_pkg::pbuf_t       pbuf,
  output logic [spp_pkg::PG_BYTES-1:0] pmask
);
  import spp_pkg::*;

  seq_e              st, st_n;
  logic [1:0]        acnt, acnt_n;
  logic [PAGE_W-1:0] page_q, page_n;
  logic [7:0]        ptr, ptr_n;
  logic              got, got_n, wel, wel_n;
  logic [PG_BYTES-1:0] mask_n;
  logic              buf_we, prot_hit;
  int unsigned       pcount;

  always_comb begin
    pcount   = (32'(PAGES) << bp) >> 7;
    prot_hit = (32'(page_q) + pcount) >= 32'(PAGES);
    go       = cs_rise && (st == ST_DATA) && aligned && got && !prot_hit;
    buf_we   = !s_cs && byte_stb && (st == ST_DATA);
    st_n = st; acnt_n = acnt; page_n = page_q; ptr_n = ptr;
    got_n = got; wel_n = wel; mask_n = pmask;
    if (go) wel_n = 1'b0;
    if (s_cs) begin
      st_n = ST_OPC;
    end else if (byte_stb) begin
      case (st)
        ST_OPC: begin
          st_n = ST_SKIP;
          if (rx_byte == OP_WREN && !busy) wel_n = 1'b1;
          if (rx_byte == OP_RDSR) st_n = ST_STAT;
          if (rx_byte == OP_PROG && wel && !busy) begin
            st_n = ST_ADDR; acnt_n = '0; mask_n = '0; got_n = 1'b0;
          end
        end
        ST_ADDR: begin
          acnt_n = acnt + 2'd1;
          if (acnt == 2'd1) page_n = rx_byte[PAGE_W-1:0];
          if (acnt == 2'd2) begin
            ptr_n = rx_byte;
            st_n  = ST_DATA;
          end
        end
        ST_DATA: begin
          mask_n[ptr] = 1'b1;
          ptr_n = ptr + 8'd1;
          got_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OPC; acnt <= '0; page_q <= '0; ptr <= '0;
      got <= 1'b0; wel <= 1'b0; pmask <= '0;
    end else begin
      st <= st_n; acnt <= acnt_n; page_q <= page_n; ptr <= ptr_n;
      got <= got_n; wel <= wel_n; pmask <= mask_n;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[ptr] <= rx_byte;
  end

  assign rd_active = (st == ST_STAT);
  assign stat      = {3'b000, bp, wel, busy};
  assign go_page   = page_q;

  AST_GO_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> wel); // R4
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel); // R10
endmodule

// File: rtl/spp_array.sv
module spp_array #(
  parameter int PAGES     = 4,
  parameter int PAGE_W    = 2,
  parameter int PROG_WAIT = 600
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go,
  input  logic [PAGE_W-1:0]            go_page,
  input  spp_pkg::pbuf_t               pbuf,
  input  logic [spp_pkg::PG_BYTES-1:0] pmask,
  input  logic [PAGE_W+7:0]            peek_addr,
  output logic [7:0]                   peek_data,
  output logic                         busy
);
  localparam int MEM_BYTES = PAGES * spp_pkg::PG_BYTES;
  localparam int TOTAL     = spp_pkg::PG_BYTES + PROG_WAIT;
  localparam int CNT_W     = $clog2(TOTAL + 1);

  logic [7:0]        mem [MEM_BYTES];
  logic              busy_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [PAGE_W-1:0] page_q, page_n;
  logic              wr_hit;
  logic [PAGE_W+7:0] waddr;

  always_comb begin
    busy_n = busy; cnt_n = cnt; page_n = page_q;
    if (go) begin
      busy_n = 1'b1; cnt_n = '0; page_n = go_page;
    end else if (busy) begin
      if (cnt == CNT_W'(TOTAL - 1)) busy_n = 1'b0;
      else cnt_n = cnt + CNT_W'(1);
    end
    waddr  = {page_q, cnt[7:0]};
    wr_hit = busy && (cnt < CNT_W'(spp_pkg::PG_BYTES)) && pmask[cnt[7:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; page_q <= '0;
    end else begin
      busy <= busy_n; cnt <= cnt_n; page_q <= page_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (wr_hit) begin
      mem[waddr] <= mem[waddr] & pbuf[cnt[7:0]];
    end
  end

  assign peek_data = mem[peek_addr];

  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R12
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt) == CNT_W'(TOTAL - 1)); // R10
endmodule

// File: rtl/spp_flash_pp.sv
module spp_flash_pp #(
  parameter int PAGES     = 4,
  parameter int PROG_WAIT = 600,
  localparam int PAGE_W   = $clog2(PAGES),
  localparam int ADDR_W   = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [2:0]        bp,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [7:0]        peek_data
);
  logic rst_meta, rst_i;
  logic s_cs, cs_rise, byte_stb, aligned, rd_active, go, busy;
  logic [7:0] rx_byte, stat;
  logic [PAGE_W-1:0] go_page;
  spp_pkg::pbuf_t pbuf;
  logic [spp_pkg::PG_BYTES-1:0] pmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0; rst_i <= 1'b0;
    end else begin
      rst_meta <= 1'b1; rst_i <= rst_meta;
    end
  end

  spp_shift u_shift (
    .clk(clk), .rst_n(rst_i), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .rd_active(rd_active), .stat(stat), .s_cs(s_cs), .cs_rise(cs_rise),
    .byte_stb(byte_stb), .rx_byte(rx_byte), .aligned(aligned), .miso(miso)
  );

  spp_ctrl #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .s_cs(s_cs), .cs_rise(cs_rise),
    .byte_stb(byte_stb), .rx_byte(rx_byte), .aligned(aligned), .busy(busy),
    .bp(bp), .rd_active(rd_active), .stat(stat), .go(go), .go_page(go_page),
    .pbuf(pbuf), .pmask(pmask)
  );

  spp_array #(.PAGES(PAGES), .PAGE_W(PAGE_W), .PROG_WAIT(PROG_WAIT)) u_array (
    .clk(clk), .rst_n(rst_i), .go(go), .go_page(go_page), .pbuf(pbuf),
    .pmask(pmask), .peek_addr(peek_addr), .peek_data(peek_data), .busy(busy)
  );
endmodule

// File: tb/spp_flash_pp_test.sv
`timescale 1ns/1ps
module spp_flash_pp_test;
  localparam int PAGES = 4;
  localparam int PROG_WAIT = 600;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [2:0] bp = 3'd0;
  logic [9:0] peek_addr = '0;
  logic miso;
  logic [7:0] peek_data;

  int checks = 0, errors = 0;
  int exp_q[$];
  int act_q[$];
  string tag_q[$];
  logic [7:0] dq[$];

  always #10 clk = ~clk;

  spp_flash_pp #(.PAGES(PAGES), .PROG_WAIT(PROG_WAIT)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .bp(bp), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  // monitor: pairs each observation with the oldest expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0 && act_q.size() > 0) begin
      int e, a;
      string t;
      e = exp_q.pop_front(); a = act_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (e != a) begin
        errors++;
        $display("FAIL %s actual %02h expected %02h", t, a, e);
      end
    end
  end

  task automatic expect_v(input string t, input int v);
    exp_q.push_back(v); tag_q.push_back(t);
  endtask

  task automatic bitx(input logic b);
    mosi = b;
    repeat (3) @(posedge clk);
    sclk = 1'b1;
    repeat (3) @(posedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bitx(v[i]);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic cs_hi();
    repeat (3) @(posedge clk);
    cs_n = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  task automatic rd_byte(output logic [7:0] s);
    for (int i = 7; i >= 0; i--) begin
      repeat (4) @(posedge clk);
      @(negedge clk) s[i] = miso;
      @(posedge clk);
      sclk = 1'b1;
      repeat (3) @(posedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic rd_stat(input string t, input int v);
    logic [7:0] s;
    cs_lo(); send_byte(8'h05); rd_byte(s); cs_hi();
    expect_v(t, v); act_q.push_back(int'(s));
  endtask

  task automatic wren();
    cs_lo(); send_byte(8'h06); cs_hi();
  endtask

  task automatic prog(input logic [23:0] a, input int extra);
    cs_lo(); send_byte(8'h02);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    foreach (dq[k]) send_byte(dq[k]);
    for (int i = 0; i < extra; i++) bitx(1'b1);
    cs_hi();
  endtask

  task automatic peek(input string t, input logic [9:0] a, input int v);
    peek_addr = a;
    @(negedge clk);
    expect_v(t, v); act_q.push_back(int'(peek_data));
  endtask

  task automatic settle();
    repeat (PROG_WAIT + 300) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s0, s1;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    expect_v("R1 miso", 0); act_q.push_back(int'(miso));
    rd_stat("R1 R3 status", 8'h00);

    // R4: no write latch
    dq = '{8'h00}; prog(24'h000000, 0); settle();
    peek("R4", 10'h000, 8'hFF);

    wren(); rd_stat("R2 wel", 8'h02);

    // R5 R10 basic program
    dq = '{8'hA5, 8'h3C, 8'h0F}; prog(24'h000010, 0);
    rd_stat("R10 busy", 8'h01);
    settle();
    rd_stat("R10 done", 8'h00);
    peek("R5", 10'h010, 8'hA5); peek("R5", 10'h011, 8'h3C);
    peek("R5", 10'h012, 8'h0F);
    peek("R6 untouched", 10'h00F, 8'hFF); peek("R6 untouched", 10'h013, 8'hFF);

    // R6 AND
    wren(); dq = '{8'hF0}; prog(24'h000010, 0); settle();
    peek("R6 and", 10'h010, 8'hA0); peek("R6 keep", 10'h011, 8'h3C);

    // R7 wrap
    wren(); dq = '{8'h11, 8'h22, 8'h33, 8'h44}; prog(24'h0001FE, 0); settle();
    peek("R7", 10'h1FE, 8'h11); peek("R7", 10'h1FF, 8'h22);
    peek("R7", 10'h100, 8'h33); peek("R7", 10'h101, 8'h44);
    peek("R7", 10'h102, 8'hFF);

    // R5 top address bits ignored
    wren(); dq = '{8'h5A}; prog(24'hC00220, 0); settle();
    peek("R5 a23a22", 10'h220, 8'h5A);

    // R8 more than a page
    wren(); dq.delete();
    for (int i = 0; i < 258; i++) dq.push_back(8'((i * 7 + 1) & 255));
    prog(24'h000300, 0); settle();
    peek("R8", 10'h300, (256 * 7 + 1) & 255);
    peek("R8", 10'h301, (257 * 7 + 1) & 255);
    peek("R8", 10'h302, (2 * 7 + 1) & 255);
    peek("R8", 10'h3FF, (255 * 7 + 1) & 255);

    // R9 misaligned select
    wren(); dq = '{8'h77}; prog(24'h000040, 3); settle();
    peek("R9", 10'h040, 8'hFF);
    rd_stat("R9 wel kept", 8'h02);
    // R9 no data byte
    dq.delete(); prog(24'h000041, 0); settle();
    rd_stat("R9 empty", 8'h02);

    // R11 protection: level 6 covers pages 2 and 3
    bp = 3'd6;
    dq = '{8'h00}; prog(24'h000230, 0); settle();
    peek("R11 blocked", 10'h230, 8'hFF);
    rd_stat("R11 R3 status", 8'h1A);
    dq = '{8'h12}; prog(24'h000180, 0); settle();
    peek("R11 open", 10'h180, 8'h12);
    rd_stat("R11 after", 8'h18);
    bp = 3'd0;

    // R12 program while busy, R2 latch ignored while busy
    wren(); dq = '{8'h00}; prog(24'h000050, 0);
    wren(); prog(24'h000060, 0); settle();
    peek("R12 first", 10'h050, 8'h00);
    peek("R12 second", 10'h060, 8'hFF);
    rd_stat("R2 busy wren", 8'h00);

    // R3 repeat
    wren();
    cs_lo(); send_byte(8'h05); rd_byte(s0); rd_byte(s1); cs_hi();
    expect_v("R3 first", 8'h02); act_q.push_back(int'(s0));
    expect_v("R3 repeat", 8'h02); act_q.push_back(int'(s1));

    repeat (10) @(posedge clk);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard actual %0d expected %0d", act_q.size(), exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule